// File: doc/BRIEF.md
# Accumulator ALU with opcode decode

This block is the accumulator arithmetic and logic unit of a small 8-bit controller core. It holds the accumulator and the carry flag. It is driven by the raw opcode byte of the instruction being executed. The upstream fetch logic presents the opcode together with a single operand byte that it has already collected. That byte may come from a working register, a direct address, an indirect pointer or the instruction stream. When the transfer is accepted, the block decodes the opcode, performs the operation and updates the accumulator and carry together in one clock edge.

The decoder also reports, combinationally, where the operand of the presented opcode lives. The fetch logic can therefore start gathering it before the transfer. The low-digit exchange alters both the accumulator and the operand location. The new operand value is therefore returned on a one-cycle write-back pulse, and the owner of that location stores it.

The input is a valid/ready stream. `in_ready` is high whenever the block is out of reset, so the block never applies back-pressure. A transfer takes place on every rising edge where `in_valid` and `in_ready` are both high, and the result is visible on `acc`/`carry` right after that edge. Holding `in_valid` low leaves all state untouched. The write-back pulse has no ready signal: the receiver must take it in the cycle it is shown.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low and right after it rises, `acc` is 0x00, `carry` is 0 and `wb_valid` is 0.
- R2: An opcode with upper nibble 0010 and a legal source field (see R6) sets acc = (acc + operand) mod 256 and carry = carry out of bit 7; the old carry has no influence.
- R3: Upper nibble 0011 with a legal source field sets acc = (acc + operand + carry) mod 256 and carry = carry out of bit 7.
- R4: Upper nibble 1001 with a legal source field sets acc = (acc - operand - carry) mod 256, and sets carry to 1 exactly when that difference is negative.
- R5: Upper nibbles 0101 (AND), 0100 (OR) and 0110 (XOR) with a legal source field apply the bitwise operation to acc and operand and leave carry unchanged.
- R6: The lower nibble is the source field. 1rrr reports src_kind 0 (register, src_reg = rrr). 0101 reports kind 1 (direct byte). 011i reports kind 2 (indirect, src_reg = i). 0100 reports kind 3 (immediate). `src_used` is 1 only for the operations of R2–R5 with a legal field and for 0xD6/0xD7 (kind 2, src_reg = opcode bit 0); otherwise src_used, src_kind and src_reg are 0.
- R7: 0x23 rotates acc left by one bit and 0x03 rotates it right by one bit; carry unchanged.
- R8: 0x33 and 0x13 rotate the 9-bit ring formed by carry and acc. 0x33 shifts left (new carry = old acc bit 7, new acc bit 0 = old carry). 0x13 shifts right (new carry = old acc bit 0, new acc bit 7 = old carry).
- R9: 0xC4 swaps the two nibbles of acc, 0xE4 clears acc, 0xF4 inverts every bit of acc; carry unchanged.
- R10: 0x04 adds one and 0x14 subtracts one from acc, wrapping modulo 256; carry unchanged.
- R11: 0xC3 clears carry, 0xD3 sets carry and 0xB3 inverts carry; acc unchanged.
- R12: 0xD6/0xD7 replace the low nibble of acc with the low nibble of the operand, leaving carry unchanged. In the cycle after the transfer `wb_valid` is 1 and `wb_data` = {operand high nibble, old acc low nibble}. `wb_valid` is 0 in every other cycle.
- R13: `in_ready` is 1 outside reset. With `in_valid` low, or with any opcode not named in R2–R12, acc and carry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode and operand presented |
| in_ready | output | 1 | Block accepts a transfer (high out of reset) |
| in_opcode | input | 8 | Instruction opcode byte |
| in_operand | input | DATA_W | Operand byte already fetched |
| src_used | output | 1 | Presented opcode consumes an operand |
| src_kind | output | 2 | Operand source: 0 register, 1 direct, 2 indirect, 3 immediate |
| src_reg | output | 3 | Register index for register or indirect source |
| acc | output | DATA_W | Accumulator |
| carry | output | 1 | Carry flag |
| wb_valid | output | 1 | Write-back of low-digit exchange result |
| wb_data | output | DATA_W | Value to store at the operand location |

## Verification
The bench builds the block with DATA_W = 8, the width the opcode set is defined for. This keeps the opcode space small enough to walk all 256 opcodes, both for the source-field outputs and for their effect on acc, carry and the write-back pulse, under a spread of accumulator, operand and carry values. The six two-operand operations are also swept over a grid of accumulator and operand values that includes 0x00 and 0xFF, with both carry inputs, so every carry-out and borrow edge is hit. Idle cycles with a live opcode on the pins check that nothing moves without a transfer.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUBB, OP_AND, OP_OR, OP_XOR,
    OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP, OP_CLR, OP_CPL,
    OP_INC, OP_DEC, OP_CLRC, OP_SETC, OP_CPLC, OP_XCHD
  } op_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_DIR = 2'd1,
    SRC_IND = 2'd2,
    SRC_IMM = 2'd3
  } src_e;

  typedef struct packed {
    op_e        op;
    logic       used;
    src_e       kind;
    logic [2:0] idx;
  } dec_t;

  // single-byte accumulator and carry opcodes
  localparam logic [OPC_W-1:0] OPC_ROT_L   = 8'h23;
  localparam logic [OPC_W-1:0] OPC_ROT_LC  = 8'h33;
  localparam logic [OPC_W-1:0] OPC_ROT_R   = 8'h03;
  localparam logic [OPC_W-1:0] OPC_ROT_RC  = 8'h13;
  localparam logic [OPC_W-1:0] OPC_NIB_SW  = 8'hC4;
  localparam logic [OPC_W-1:0] OPC_ZERO    = 8'hE4;
  localparam logic [OPC_W-1:0] OPC_INVERT  = 8'hF4;
  localparam logic [OPC_W-1:0] OPC_BUMP_UP = 8'h04;
  localparam logic [OPC_W-1:0] OPC_BUMP_DN = 8'h14;
  localparam logic [OPC_W-1:0] OPC_C_ZERO  = 8'hC3;
  localparam logic [OPC_W-1:0] OPC_C_ONE   = 8'hD3;
  localparam logic [OPC_W-1:0] OPC_C_FLIP  = 8'hB3;
  localparam logic [OPC_W-2:0] OPC_DIGX    = 7'b1101_011; // 0xD6 / 0xD7

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);

  logic [3:0] hi_nib;
  logic [3:0] lo_nib;
  logic       src_ok;
  src_e       src_kind;
  logic [2:0] src_idx;
  op_e        pair_op;

  assign hi_nib = opcode[7:4];
  assign lo_nib = opcode[3:0];

  // source field in the low nibble
  always_comb begin
    src_ok   = 1'b1;
    src_kind = SRC_REG;
    src_idx  = 3'd0;
    if (lo_nib[3]) begin
      src_kind = SRC_REG;
      src_idx  = lo_nib[2:0];
    end else if (lo_nib == 4'h5) begin
      src_kind = SRC_DIR;
    end else if (lo_nib[3:1] == 3'b011) begin
      src_kind = SRC_IND;
      src_idx  = {2'b00, lo_nib[0]};
    end else if (lo_nib == 4'h4) begin
      src_kind = SRC_IMM;
    end else begin
      src_ok   = 1'b0;
    end
  end

  // two-operand operation in the high nibble
  always_comb begin
    unique case (hi_nib)
      4'h2:    pair_op = OP_ADD;
      4'h3:    pair_op = OP_ADDC;
      4'h9:    pair_op = OP_SUBB;
      4'h5:    pair_op = OP_AND;
      4'h4:    pair_op = OP_OR;
      4'h6:    pair_op = OP_XOR;
      default: pair_op = OP_NONE;
    endcase
  end

  always_comb begin
    dec.op   = OP_NONE;
    dec.used = 1'b0;
    dec.kind = SRC_REG;
    dec.idx  = 3'd0;
    if (src_ok && (pair_op != OP_NONE)) begin
      dec.op   = pair_op;
      dec.used = 1'b1;
      dec.kind = src_kind;
      dec.idx  = src_idx;
    end else if (opcode[OPC_W-1:1] == OPC_DIGX) begin
      dec.op   = OP_XCHD;
      dec.used = 1'b1;
      dec.kind = SRC_IND;
      dec.idx  = {2'b00, opcode[0]};
    end else begin
      unique case (opcode)
        OPC_ROT_L:   dec.op = OP_RL;
        OPC_ROT_LC:  dec.op = OP_RLC;
        OPC_ROT_R:   dec.op = OP_RR;
        OPC_ROT_RC:  dec.op = OP_RRC;
        OPC_NIB_SW:  dec.op = OP_SWAP;
        OPC_ZERO:    dec.op = OP_CLR;
        OPC_INVERT:  dec.op = OP_CPL;
        OPC_BUMP_UP: dec.op = OP_INC;
        OPC_BUMP_DN: dec.op = OP_DEC;
        OPC_C_ZERO:  dec.op = OP_CLRC;
        OPC_C_ONE:   dec.op = OP_SETC;
        OPC_C_FLIP:  dec.op = OP_CPLC;
        default:     dec.op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W:0] wide;
  logic [W:0] cin_w;

  assign cin_w = {{W{1'b0}}, cin};

  // for subtraction the top bit of the (W+1)-bit difference is the borrow
  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b} - cin_w;
    else     wide = {1'b0, a} + {1'b0, b} + cin_w;
  end

  assign res  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] acc_nx,
  output logic         c_nx,
  output logic [W-1:0] wb_nx
);

  localparam int H = W / 2;

  logic         as_sub;
  logic         as_cin;
  logic [W-1:0] as_res;
  logic         as_cout;
  logic [W-1:0] swapped;

  assign as_sub = (op == OP_SUBB);
  assign as_cin = cin & ((op == OP_ADDC) || (op == OP_SUBB));

  acc_alu_addsub #(.W(W)) u_addsub (
    .a    (a),
    .b    (b),
    .cin  (as_cin),
    .sub  (as_sub),
    .res  (as_res),
    .cout (as_cout)
  );

  // nibble exchange wiring, one bit at a time
  for (genvar i = 0; i < W; i++) begin : g_swap
    assign swapped[i] = a[(i + H) % W];
  end

  assign wb_nx = {b[W-1:H], a[H-1:0]};

  always_comb begin
    acc_nx = a;
    c_nx   = cin;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_nx = as_res;
        c_nx   = as_cout;
      end
      OP_AND:  acc_nx = a & b;
      OP_OR:   acc_nx = a | b;
      OP_XOR:  acc_nx = a ^ b;
      OP_RL:   acc_nx = {a[W-2:0], a[W-1]};
      OP_RR:   acc_nx = {a[0], a[W-1:1]};
      OP_RLC: begin
        acc_nx = {a[W-2:0], cin};
        c_nx   = a[W-1];
      end
      OP_RRC: begin
        acc_nx = {cin, a[W-1:1]};
        c_nx   = a[0];
      end
      OP_SWAP: acc_nx = swapped;
      OP_CLR:  acc_nx = '0;
      OP_CPL:  acc_nx = ~a;
      OP_INC:  acc_nx = a + W'(1);
      OP_DEC:  acc_nx = a - W'(1);
      OP_CLRC: c_nx   = 1'b0;
      OP_SETC: c_nx   = 1'b1;
      OP_CPLC: c_nx   = ~cin;
      OP_XCHD: acc_nx = {a[W-1:H], b[H-1:0]};
      default: begin
        acc_nx = a;
        c_nx   = cin;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  output logic              src_used,
  output logic [1:0]        src_kind,
  output logic [2:0]        src_reg,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data
);

  dec_t              dec;
  logic              fire;
  logic [DATA_W-1:0] acc_q;
  logic              c_q;
  logic              wb_q;
  logic [DATA_W-1:0] wb_data_q;
  logic [DATA_W-1:0] acc_nx;
  logic              c_nx;
  logic [DATA_W-1:0] wb_nx;

  acc_alu_decode u_decode (
    .opcode (in_opcode),
    .dec    (dec)
  );

  acc_alu_exec #(.W(DATA_W)) u_exec (
    .op     (dec.op),
    .a      (acc_q),
    .b      (in_operand),
    .cin    (c_q),
    .acc_nx (acc_nx),
    .c_nx   (c_nx),
    .wb_nx  (wb_nx)
  );

  assign in_ready = rst_n;
  assign fire     = in_valid && in_ready;

  assign src_used = dec.used;
  assign src_kind = dec.kind;
  assign src_reg  = dec.idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      c_q   <= 1'b0;
    end else if (fire) begin
      acc_q <= acc_nx;
      c_q   <= c_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q      <= 1'b0;
      wb_data_q <= '0;
    end else begin
      wb_q <= fire && (dec.op == OP_XCHD);
      if (fire && (dec.op == OP_XCHD)) wb_data_q <= wb_nx;
    end
  end

  assign acc      = acc_q;
  assign carry    = c_q;
  assign wb_valid = wb_q;
  assign wb_data  = wb_data_q;

  // state after reset (R1)
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (acc_q == '0) && !c_q && !wb_q);

  // no transfer, no change (R13)
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q) && $stable(c_q));

  // bitwise operations keep carry (R5)
  p_logic_keeps_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op inside {OP_AND, OP_OR, OP_XOR}) |=> $stable(c_q));

  // 9-bit ring: carry takes the bit shifted out (R8)
  p_ring_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op == OP_RLC) |=> c_q == $past(acc_q[DATA_W-1]));

  p_ring_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op == OP_RRC) |=> c_q == $past(acc_q[0]));

  // step operations keep carry (R10)
  p_step_keeps_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op inside {OP_INC, OP_DEC}) |=> $stable(c_q));

  // carry opcodes keep the accumulator (R11)
  p_cflag_keeps_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op inside {OP_CLRC, OP_SETC, OP_CPLC}) |=> $stable(acc_q));

  // write-back pulse exactly one cycle after a digit exchange (R12)
  p_wb_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (dec.op == OP_XCHD) |=> wb_q);

  p_wb_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && (dec.op == OP_XCHD)) |=> !wb_q);

  // operand source is reported only for operand-consuming opcodes (R6)
  p_src_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_used |-> (src_kind == 2'd0) && (src_reg == 3'd0));

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_opcode = 8'h00;
  logic [W-1:0] in_operand = '0;
  logic         src_used;
  logic [1:0]   src_kind;
  logic [2:0]   src_reg;
  logic [W-1:0] acc;
  logic         carry;
  logic         wb_valid;
  logic [W-1:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  acc_alu #(.DATA_W(W)) u_acc_alu (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_opcode  (in_opcode),
    .in_operand (in_operand),
    .src_used   (src_used),
    .src_kind   (src_kind),
    .src_reg    (src_reg),
    .acc        (acc),
    .carry      (carry),
    .wb_valid   (wb_valid),
    .wb_data    (wb_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {carry, acc} after one transfer, from the requirement text
  function automatic logic [8:0] model(input logic [7:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    int s;
    logic [3:0] hi, lo;
    logic ok;
    hi = op[7:4];
    lo = op[3:0];
    ok = (lo >= 4'd8) || (lo == 4'd4) || (lo == 4'd5) || (lo == 4'd6) || (lo == 4'd7);
    model = {c, a};
    if (ok && hi == 4'h2) begin s = a + b; model = {1'(s > 255), 8'(s)}; end
    else if (ok && hi == 4'h3) begin s = a + b + c; model = {1'(s > 255), 8'(s)}; end
    else if (ok && hi == 4'h9) begin
      s = int'(a) - int'(b) - int'(c);
      model = {1'(s < 0), 8'(s)};
    end
    else if (ok && hi == 4'h5) model = {c, a & b};
    else if (ok && hi == 4'h4) model = {c, a | b};
    else if (ok && hi == 4'h6) model = {c, a ^ b};
    else begin
      case (op)
        8'h23: model = {c, a[6:0], a[7]};
        8'h03: model = {c, a[0], a[7:1]};
        8'h33: model = {a[7], a[6:0], c};
        8'h13: model = {a[0], c, a[7:1]};
        8'hC4: model = {c, a[3:0], a[7:4]};
        8'hE4: model = {c, 8'h00};
        8'hF4: model = {c, ~a};
        8'h04: model = {c, 8'(a + 1)};
        8'h14: model = {c, 8'(a - 1)};
        8'hC3: model = {1'b0, a};
        8'hD3: model = {1'b1, a};
        8'hB3: model = {~c, a};
        8'hD6, 8'hD7: model = {c, a[7:4], b[3:0]};
        default: model = {c, a};
      endcase
    end
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    logic [3:0] lo;
    logic ok;
    lo = op[3:0];
    ok = (lo >= 4'd8) || (lo == 4'd4) || (lo == 4'd5) || (lo == 4'd6) || (lo == 4'd7);
    if (ok && op[7:4] == 4'h2) return "R2";
    if (ok && op[7:4] == 4'h3) return "R3";
    if (ok && op[7:4] == 4'h9) return "R4";
    if (ok && (op[7:4] == 4'h4 || op[7:4] == 4'h5 || op[7:4] == 4'h6)) return "R5";
    case (op)
      8'h23, 8'h03: return "R7";
      8'h33, 8'h13: return "R8";
      8'hC4, 8'hE4, 8'hF4: return "R9";
      8'h04, 8'h14: return "R10";
      8'hC3, 8'hD3, 8'hB3: return "R11";
      8'hD6, 8'hD7: return "R12";
      default: return "R13";
    endcase
  endfunction

  // {used, kind[1:0], reg[2:0]} per R6
  function automatic logic [5:0] src_of(input logic [7:0] op);
    logic [3:0] hi, lo;
    hi = op[7:4];
    lo = op[3:0];
    if (op == 8'hD6) return {1'b1, 2'd2, 3'd0};
    if (op == 8'hD7) return {1'b1, 2'd2, 3'd1};
    if (!(hi == 4'h2 || hi == 4'h3 || hi == 4'h9 || hi == 4'h4 || hi == 4'h5 || hi == 4'h6))
      return 6'd0;
    if (lo >= 4'd8) return {1'b1, 2'd0, lo[2:0]};
    if (lo == 4'd5) return {1'b1, 2'd1, 3'd0};
    if (lo == 4'd6 || lo == 4'd7) return {1'b1, 2'd2, 2'b00, lo[0]};
    if (lo == 4'd4) return {1'b1, 2'd3, 3'd0};
    return 6'd0;
  endfunction

  task automatic exec(input logic [7:0] op, input logic [7:0] b);
    @(negedge clk);
    in_valid   = 1'b1;
    in_opcode  = op;
    in_operand = b;
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [7:0] a, input logic c);
    exec(8'hE4, 8'h00);
    exec(8'h24, a);
    if (c) exec(8'hD3, 8'h00);
  endtask

  task automatic run_one(input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic c);
    logic [8:0] exp;
    string t;
    exp = model(op, a, b, c);
    t = tag_of(op);
    load(a, c);
    exec(op, b);
    settle();
    chk(t, $sformatf("acc op=%02h a=%02h b=%02h c=%0d", op, a, b, c), acc, exp[7:0]);
    chk(t, $sformatf("carry op=%02h a=%02h b=%02h c=%0d", op, a, b, c), carry, exp[8]);
    if (op == 8'hD6 || op == 8'hD7) begin
      chk("R12", "wb_valid", wb_valid, 1);
      chk("R12", $sformatf("wb_data a=%02h b=%02h", a, b), wb_data, {b[7:4], a[3:0]});
    end else begin
      chk("R12", $sformatf("wb_valid idle op=%02h", op), wb_valid, 0);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    ops = '{8'h24, 8'h34, 8'h94, 8'h54, 8'h44, 8'h64};
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "acc in reset", acc, 0);
    chk("R1", "carry in reset", carry, 0);
    chk("R1", "wb_valid in reset", wb_valid, 0);
    chk("R13", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "acc after reset", acc, 0);
    chk("R1", "carry after reset", carry, 0);
    chk("R13", "in_ready out of reset", in_ready, 1);

    // R6: source field for every opcode
    for (int op = 0; op < 256; op++) begin
      logic [5:0] e;
      @(negedge clk);
      in_opcode = 8'(op);
      #1;
      e = src_of(8'(op));
      chk("R6", $sformatf("src_used op=%02h", op), src_used, e[5]);
      chk("R6", $sformatf("src_kind op=%02h", op), src_kind, e[4:3]);
      chk("R6", $sformatf("src_reg op=%02h", op), src_reg, e[2:0]);
    end

    // R2-R5: grid sweep of the two-operand operations, immediate source
    for (int k = 0; k < 6; k++) begin
      for (int ia = 0; ia < 52; ia++) begin
        for (int jb = 0; jb < 38; jb++) begin
          for (int c = 0; c < 2; c++) begin
            run_one(ops[k], 8'(ia * 5), (jb == 37) ? 8'hFF : 8'(jb * 7), 1'(c));
          end
        end
      end
    end

    // R2-R13: every opcode under a spread of states
    for (int op = 0; op < 256; op++) begin
      for (int p = 0; p < 20; p++) begin
        run_one(8'(op), 8'((p * 53 + op) & 255), 8'((p * 97 + 13) & 255), 1'(p & 1));
      end
    end

    // R13: idle cycles with a live opcode change nothing
    load(8'h5A, 1'b1);
    settle();
    in_opcode  = 8'hF4;
    in_operand = 8'h33;
    repeat (5) @(negedge clk);
    chk("R13", "acc while idle", acc, 8'h5A);
    chk("R13", "carry while idle", carry, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule